// File: doc/BRIEF.md
# Banked Data Pointer Unit

This block keeps two 16-bit data pointers for an 8-bit microcontroller core and presents whichever one is active as a 16-bit memory address. A single select flag in a small control register picks the active pointer. Software reaches that register and both bytes of the active pointer through an 8-bit special-function-register (SFR) port. The low and high pointer bytes sit at one fixed pair of addresses, and that pair always refers to the active pointer.

The instruction sequencer drives a 2-bit pointer command each cycle. The command can increment the active pointer or load a 16-bit constant into it. For indexed code reads and indirect jumps the sequencer raises an index strobe, and the address output is then the active pointer plus the unsigned accumulator byte. The pointer itself does not change. The select flag sits in bit 0, and bits 1 and 2 of the control register always read as zero. Because of this, a read-modify-write increment of the control register flips the active pointer and leaves the two upper control flags as they were.

Top module: `dptr_unit`

## Requirements
- R1: After a synchronous active-low reset both pointers hold 0x0000, pointer 0 is active, and the control register at 0xA2 reads 0x00.
- R2: Bit 0 of the control register selects the active pointer (0 selects pointer 0, 1 selects pointer 1). SFR writes to 0x82 and 0x83 replace the low and high byte of the active pointer only. Reads of 0x82 and 0x83 return the active pointer's bytes. The inactive pointer never changes.
- R3: In the control register at 0xA2, bits 0, 3 and 4 are writable. Bits 1, 2 and 7..5 discard written data and always read 0, so writing 0xFF reads back 0x19.
- R4: A read of 0xA2, followed by a write of that value plus one, toggles bit 0 and leaves bits 3 and 4 unchanged, for either value of bit 0.
- R5: Command 2'b01 adds one to the active pointer on the next clock edge. The carry passes from the low byte into the high byte, and 0xFFFF wraps to 0x0000. Commands 2'b00 and 2'b11 change nothing.
- R6: Command 2'b10 loads the 16-bit immediate into the active pointer in one cycle.
- R7: With the index strobe low, the address output equals the active pointer. With it high, the output equals the active pointer plus the zero-extended accumulator, modulo 2^16. Indexing never modifies a pointer.
- R8: When an SFR byte write to 0x82 or 0x83 and a command of 2'b01 or 2'b10 fall in the same cycle, the command's result is stored and the byte write is dropped.
- R9: Read data is combinational. It is 0x00 while the read strobe is low, and 0x00 for any address other than 0x82, 0x83 and 0xA2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfr_addr | input | 8 | SFR address |
| sfr_wdata | input | 8 | SFR write data |
| sfr_we | input | 1 | SFR write strobe |
| sfr_re | input | 1 | SFR read strobe |
| sfr_rdata | output | 8 | SFR read data (combinational) |
| ptr_cmd | input | 2 | Pointer command: 00 idle, 01 increment, 10 load, 11 idle |
| ptr_imm | input | 16 | Immediate for the load command |
| acc | input | 8 | Accumulator offset for indexed addressing |
| idx_en | input | 1 | Selects pointer-plus-accumulator addressing |
| mem_addr | output | 16 | Memory address derived from the active pointer |

## Verification
Every pointer and select bit reaches the address output in the same cycle. A wrong select flag, a lost carry or a dropped command therefore shows up on `mem_addr` at the first sampling point after the faulty edge. Damage to the inactive pointer stays hidden until the select flag is flipped, so the bench toggles the flag often and reads both pointers back over the SFR port. A reference model in the bench is compared against both outputs on every cycle. The bench stresses priority collisions, the 0xFFFF wrap, carries out of the low byte, and the control-register increment from both select values.

// File: rtl/dptr_pkg.sv
// Shared types for the banked data pointer unit.
// Assumes: command codes are fixed by the core's sequencer.
package dptr_pkg;
    typedef enum logic [1:0] {
        PCMD_IDLE = 2'b00,
        PCMD_INC  = 2'b01,
        PCMD_LOAD = 2'b10,
        PCMD_RSVD = 2'b11
    } ptr_cmd_e;
endpackage

// File: rtl/dptr_sel_reg.sv
// Control register holding the pointer select flag and two spare control flags.
// Only bits set in KEEP_MASK store data; all other bits read back as zero, so a
// carry out of the select bit during a read-modify-write increment is lost.
// Assumes: wr_en is already decoded from the SFR address and write strobe.
module dptr_sel_reg #(
    parameter int          DW        = 8,
    parameter logic [DW-1:0] KEEP_MASK = 8'h19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] ctrl_q,
    output logic          sel_o
);
    // Store the masked write data; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en)
            ctrl_q <= wdata & KEEP_MASK;
    end

    // Select flag is bit 0.
    always_comb sel_o = ctrl_q[0];

    assert_sel_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> sel_o == $past(wdata[0]));
    assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_q));
    assert_rmw_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata == ctrl_q + 1'b1) |=>
            (sel_o != $past(sel_o)) && (ctrl_q[4:3] == $past(ctrl_q[4:3])));
endmodule

// File: rtl/dptr_reg.sv
// One 16-bit data pointer with increment, load and SFR byte-write paths.
// A pointer command beats an SFR byte write in the same cycle.
// Assumes: W == 2*BW (one low and one high SFR byte); writes arrive ungated.
module dptr_reg
    import dptr_pkg::*;
#(
    parameter int W  = 16,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  ptr_cmd_e      cmd,
    input  logic [W-1:0]  imm,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [BW-1:0] wbyte,
    output logic [W-1:0]  q
);
    localparam int HI_W = W - BW;

    logic do_inc, do_load, do_lo, do_hi;

    // Qualify the update sources with the select and the priority order.
    always_comb begin
        do_inc  = active && (cmd == PCMD_INC);
        do_load = active && (cmd == PCMD_LOAD);
        do_lo   = active && wr_lo && !do_inc && !do_load;
        do_hi   = active && wr_hi && !do_inc && !do_load;
    end

    // Pointer state update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (do_load)
            q <= imm;
        else if (do_inc)
            q <= q + W'(1);
        else begin
            if (do_lo) q[BW-1:0] <= wbyte;
            if (do_hi) q[W-1:BW] <= wbyte[HI_W-1:0];
        end
    end

    assert_inactive_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> $stable(q));
    assert_inc_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cmd == PCMD_INC && q == {W{1'b1}}) |=> q == '0);
    assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cmd == PCMD_LOAD) |=> q == $past(imm));
    assert_cmd_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cmd == PCMD_INC && (wr_lo || wr_hi)) |=> q == $past(q) + W'(1));
endmodule

// File: rtl/dptr_addr_gen.sv
// Forms the memory address from the active pointer, optionally adding the
// zero-extended accumulator for indexed code reads and indirect jumps.
// Assumes: OW <= W; the sum wraps modulo 2^W.
module dptr_addr_gen #(
    parameter int W  = 16,
    parameter int OW = 8
) (
    input  logic [W-1:0]  base,
    input  logic [OW-1:0] off,
    input  logic          idx_en,
    output logic [W-1:0]  addr
);
    // Single adder after the pointer mux.
    always_comb addr = idx_en ? base + {{(W-OW){1'b0}}, off} : base;
endmodule

// File: rtl/dptr_unit.sv
// Top of the banked data pointer unit: decodes SFR accesses, instantiates the
// control register and two pointers, muxes the active pointer and read data.
// Assumes: SFR reads are combinational and strobed by sfr_re.
module dptr_unit
    import dptr_pkg::*;
#(
    parameter int         PTR_W    = 16,
    parameter int         SFR_AW   = 8,
    parameter int         SFR_DW   = 8,
    parameter int         ACC_W    = 8,
    parameter logic [7:0] LO_ADDR  = 8'h82,
    parameter logic [7:0] HI_ADDR  = 8'h83,
    parameter logic [7:0] SEL_ADDR = 8'hA2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SFR_AW-1:0] sfr_addr,
    input  logic [SFR_DW-1:0] sfr_wdata,
    input  logic              sfr_we,
    input  logic              sfr_re,
    output logic [SFR_DW-1:0] sfr_rdata,
    input  logic [1:0]        ptr_cmd,
    input  logic [PTR_W-1:0]  ptr_imm,
    input  logic [ACC_W-1:0]  acc,
    input  logic              idx_en,
    output logic [PTR_W-1:0]  mem_addr
);
    localparam int NUM_PTR = 2;

    ptr_cmd_e          cmd;
    logic              hit_lo_w, hit_hi_w, hit_sel_w;
    logic [SFR_DW-1:0] ctrl_q;
    logic              sel;
    logic [PTR_W-1:0]  ptr_q [NUM_PTR];
    logic [PTR_W-1:0]  act_ptr;

    // Convert the raw command bits to the enum.
    always_comb cmd = ptr_cmd_e'(ptr_cmd);

    // Write decode for the three SFR locations.
    always_comb begin
        hit_lo_w  = sfr_we && (sfr_addr == LO_ADDR);
        hit_hi_w  = sfr_we && (sfr_addr == HI_ADDR);
        hit_sel_w = sfr_we && (sfr_addr == SEL_ADDR);
    end

    dptr_sel_reg #(.DW(SFR_DW)) u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (hit_sel_w),
        .wdata  (sfr_wdata),
        .ctrl_q (ctrl_q),
        .sel_o  (sel)
    );

    for (genvar k = 0; k < NUM_PTR; k++) begin : g_ptr
        dptr_reg #(.W(PTR_W), .BW(SFR_DW)) u_ptr (
            .clk    (clk),
            .rst_n  (rst_n),
            .active (sel == 1'(k)),
            .cmd    (cmd),
            .imm    (ptr_imm),
            .wr_lo  (hit_lo_w),
            .wr_hi  (hit_hi_w),
            .wbyte  (sfr_wdata),
            .q      (ptr_q[k])
        );
    end

    // Active pointer mux.
    always_comb act_ptr = ptr_q[sel];

    dptr_addr_gen #(.W(PTR_W), .OW(ACC_W)) u_agen (
        .base   (act_ptr),
        .off    (acc),
        .idx_en (idx_en),
        .addr   (mem_addr)
    );

    // Combinational SFR read mux, zero when not strobed or unmapped.
    always_comb begin
        sfr_rdata = '0;
        if (sfr_re) begin
            if (sfr_addr == LO_ADDR)       sfr_rdata = act_ptr[SFR_DW-1:0];
            else if (sfr_addr == HI_ADDR)  sfr_rdata = act_ptr[PTR_W-1:SFR_DW];
            else if (sfr_addr == SEL_ADDR) sfr_rdata = ctrl_q;
        end
    end

    assert_idle_no_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != PCMD_INC && cmd != PCMD_LOAD && !sfr_we) |=>
            $stable(ptr_q[0]) && $stable(ptr_q[1]));
    assert_fixed_zero_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_re && sfr_addr == SEL_ADDR) |-> sfr_rdata[2:1] == 2'b00);
    assert_quiet_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sfr_re |-> sfr_rdata == '0);
    assert_reset_sel_R1: assert property (@(posedge clk)
        !rst_n |=> (sel == 1'b0) && (mem_addr == '0 || idx_en));
endmodule

// File: tb/dptr_unit_test.sv
`timescale 1ns/1ps
module dptr_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sfr_addr = '0, sfr_wdata = '0, acc = '0;
    logic        sfr_we = 1'b0, sfr_re = 1'b0, idx_en = 1'b0;
    logic [1:0]  ptr_cmd = '0;
    logic [15:0] ptr_imm = '0;
    logic [7:0]  sfr_rdata;
    logic [15:0] mem_addr;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_ptr [2];
    logic [7:0]  m_ctrl;

    always #2 clk = ~clk;

    dptr_unit uut (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
        .sfr_we(sfr_we), .sfr_re(sfr_re), .sfr_rdata(sfr_rdata),
        .ptr_cmd(ptr_cmd), .ptr_imm(ptr_imm), .acc(acc), .idx_en(idx_en),
        .mem_addr(mem_addr)
    );

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: sfr_rdata actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check16(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: mem_addr actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare outputs with the model, clock, update model.
    task automatic step(string tag, logic [7:0] a, logic [7:0] wd, logic we, logic re,
                        logic [1:0] cmd, logic [15:0] imm, logic [7:0] ac, logic ix);
        logic [15:0] cur;
        logic [7:0]  exp_rd;
        int s;
        sfr_addr = a; sfr_wdata = wd; sfr_we = we; sfr_re = re;
        ptr_cmd = cmd; ptr_imm = imm; acc = ac; idx_en = ix;
        #1;
        s = int'(m_ctrl[0]);
        cur = m_ptr[s];
        exp_rd = 8'h00;
        if (re) begin
            if (a == 8'h82) exp_rd = cur[7:0];
            else if (a == 8'h83) exp_rd = cur[15:8];
            else if (a == 8'hA2) exp_rd = m_ctrl;
        end
        check8(tag, sfr_rdata, exp_rd);
        check16(tag, mem_addr, ix ? cur + {8'h00, ac} : cur);
        @(posedge clk);
        if (cmd == 2'b01) m_ptr[s] = cur + 16'd1;
        else if (cmd == 2'b10) m_ptr[s] = imm;
        else if (we && a == 8'h82) m_ptr[s][7:0] = wd;
        else if (we && a == 8'h83) m_ptr[s][15:8] = wd;
        if (we && a == 8'hA2) m_ctrl = wd & 8'h19;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        m_ptr[0] = '0; m_ptr[1] = '0; m_ctrl = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        step("R1", 8'hA2, 0, 0, 1, 0, 0, 0, 0);
        step("R1", 8'h82, 0, 0, 1, 0, 0, 0, 0);
        step("R1", 8'h83, 0, 0, 1, 0, 0, 0, 0);
        // R2: byte writes to pointer 0
        step("R2", 8'h82, 8'h34, 1, 0, 0, 0, 0, 0);
        step("R2", 8'h83, 8'h12, 1, 0, 0, 0, 0, 0);
        step("R2", 8'h83, 0, 0, 1, 0, 0, 0, 0);
        // R3: write all ones to control register, reads back 0x19
        step("R3", 8'hA2, 8'hFF, 1, 0, 0, 0, 0, 0);
        step("R3", 8'hA2, 0, 0, 1, 0, 0, 0, 0);
        check8("R3", m_ctrl, 8'h19);
        // R2: pointer 1 bytes, pointer 0 left alone
        step("R2", 8'h82, 8'hCD, 1, 0, 0, 0, 0, 0);
        step("R2", 8'h83, 8'hAB, 1, 1, 0, 0, 0, 0);
        // R4: read-modify-write increments from both select values
        step("R4", 8'hA2, 0, 0, 1, 0, 0, 0, 0);
        step("R4", 8'hA2, m_ctrl + 8'd1, 1, 0, 0, 0, 0, 0);
        step("R4", 8'h82, 0, 0, 1, 0, 0, 0, 0);
        check8("R4", m_ctrl, 8'h18);
        step("R4", 8'hA2, m_ctrl + 8'd1, 1, 1, 0, 0, 0, 0);
        step("R4", 8'h83, 0, 0, 1, 0, 0, 0, 0);
        check8("R4", m_ctrl, 8'h19);
        // R6 / R5: load and wrap on pointer 1
        step("R6", 8'h00, 0, 0, 0, 2'b10, 16'hFFFF, 0, 0);
        step("R5", 8'h00, 0, 0, 0, 2'b01, 0, 0, 0);
        step("R5", 8'h00, 0, 0, 0, 2'b10, 16'h00FF, 0, 0);
        step("R5", 8'h00, 0, 0, 0, 2'b01, 0, 0, 0);
        step("R5", 8'h00, 0, 0, 0, 2'b11, 16'h5555, 0, 0);
        step("R5", 8'h83, 0, 0, 1, 2'b00, 16'h5555, 0, 0);
        check16("R5", m_ptr[1], 16'h0100);
        // R7: indexed address wraps, pointer untouched
        step("R7", 8'h00, 0, 0, 0, 2'b10, 16'hFFF0, 0, 0);
        step("R7", 8'h00, 0, 0, 0, 0, 0, 8'hFF, 1);
        step("R7", 8'h00, 0, 0, 0, 0, 0, 8'h10, 1);
        step("R7", 8'h82, 0, 0, 1, 0, 0, 8'h10, 0);
        check16("R7", m_ptr[1], 16'hFFF0);
        // R8: command beats byte write
        step("R8", 8'h82, 8'h00, 1, 0, 2'b01, 0, 0, 0);
        step("R8", 8'h83, 8'h00, 1, 0, 2'b10, 16'h2468, 0, 0);
        step("R8", 8'h83, 0, 0, 1, 0, 0, 0, 0);
        check16("R8", m_ptr[1], 16'h2468);
        // R9: quiet and unmapped reads
        step("R9", 8'h82, 0, 0, 0, 0, 0, 0, 0);
        step("R9", 8'h80, 0, 0, 1, 0, 0, 0, 0);
        step("R9", 8'hA3, 0, 0, 1, 0, 0, 0, 0);
        // Mixed traffic, all requirements against the model
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a;
            case ($urandom % 5)
                0: a = 8'h82;
                1: a = 8'h83;
                2: a = 8'hA2;
                3: a = 8'h81;
                default: a = 8'h82;
            endcase
            step("R2", a, 8'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
                 16'($urandom), 8'($urandom), 1'($urandom));
        end
        // R1: reset again mid-run
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        m_ptr[0] = '0; m_ptr[1] = '0; m_ctrl = '0;
        rst_n = 1'b1;
        step("R1", 8'hA2, 0, 0, 1, 0, 0, 0, 0);
        step("R1", 8'h83, 0, 0, 1, 0, 0, 0, 0);
        finish_run();
    end
endmodule